// File: doc/BRIEF.md
# Four-Channel Debug Breakpoint Matcher

The block watches two address streams, the instruction-fetch address and the data-access address, and compares both against four programmable breakpoint channels in the same cycle. It never stalls either stream. Each channel holds an address, an enable, a match kind and a length. A channel of the execution kind fires when an instruction is fetched from exactly its address. A channel of a data kind fires when a data access overlaps its byte range. One data kind reacts to reads only. The other reacts to both reads and writes. Matching depends on nothing but the channel settings and the access itself; no privilege or protection input exists.

When any channel matches, the block raises a one-cycle trap and presents a vector showing which channels matched. It also latches the matched channels into a sticky status register, which software reads and clears through a small register port. The block keeps no state machine. Its only sequential state is the channel configuration, the sticky status, and the registered trap and hit outputs.

Top module: `bkpt_matcher`

## Requirements
- R1: After reset every channel is disabled with address and control zero, the status register reads 0, and `trap` and `hit_vec` are 0.
- R2: A channel that is enabled with kind execution (control bits [2:1] = 0) matches when `fetch_valid` is high and `fetch_addr` equals its address register exactly.
- R3: A channel of kind read-only data (kind = 1) matches data reads and never matches an access with `data_wr` = 1.
- R4: A channel of kind read-or-write data (kind = 2) matches both data reads and data writes.
- R5: The length code in control bits [4:3] gives 1 byte (0), 2 bytes (1) or 4 bytes (2 or 3). The range starts at the channel address with its low bits cleared to that alignment. A data access of `data_size` 0/1/2/3 covers 1/2/4/4 bytes from `data_addr`, and it matches if any of those bytes falls in the range. Execution channels ignore data accesses, and data channels ignore fetches.
- R6: A channel whose enable bit (control bit 0) is clear, or whose kind is 3, never matches and never sets its status bit.
- R7: All channels are checked in parallel every cycle. The inputs of cycle N appear in `hit_vec` (bit i = channel i) after the next rising edge. `trap` is high for exactly that cycle whenever `hit_vec` is non-zero, even when several channels match or when a fetch and a data access both match.
- R8: Each match sets its status bit on the same edge that updates `hit_vec`. A status bit stays set until software writes 1 to that bit of the status register. When a clear and a new match hit the same bit in one cycle, the match wins.
- R9: `reg_sel` bits [3:2] pick the group: 0 = channel address, 1 = channel control (5 bits, zero-extended), 2 = status (4 bits), 3 = reserved (reads 0, writes ignored). Bits [1:0] pick the channel. A write takes effect at the next rising edge, and `reg_rdata` shows the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select: group in [3:2], channel in [1:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| fetch_valid | input | 1 | Instruction-fetch address is valid |
| fetch_addr | input | 32 | Instruction-fetch address |
| data_valid | input | 1 | Data access is valid |
| data_wr | input | 1 | Data access is a write |
| data_addr | input | 32 | Data access start address |
| data_size | input | 2 | Data access size code |
| trap | output | 1 | One-cycle breakpoint trap |
| hit_vec | output | 4 | Channels that matched the previous cycle's accesses |

## Verification
Directed accesses touch the first and last byte of each range and the byte just outside it. Among them is a 4-byte access that straddles two overlapping ranges, which shows whether the range arithmetic is inclusive and aligned. A fetch and a data access of equal address are sent to channels of each kind, and a write goes to a read-only channel, to show that kind filtering works. A simultaneous fetch and data hit on three channels, followed by an idle cycle, shows parallel matching and the single trap pulse. A long random phase then mixes configuration rewrites, status clears and accesses clustered around the programmed addresses, and compares every cycle against a behavioural model.

// File: rtl/bkpt_pkg.sv
`timescale 1ns/1ps
package bkpt_pkg;

    // Match kind of a channel
    typedef enum logic [1:0] {
        KIND_EXEC = 2'd0,
        KIND_RD   = 2'd1,
        KIND_RW   = 2'd2,
        KIND_OFF  = 2'd3
    } bp_kind_e;

    // Control word: len_code [4:3], kind [2:1], en [0]
    typedef struct packed {
        logic [1:0] len_code;
        bp_kind_e   kind;
        logic       en;
    } bp_ctl_t;

    localparam int CTL_W = $bits(bp_ctl_t);

    // Register group selected by the upper select bits
    typedef enum logic [1:0] {
        GRP_ADDR = 2'd0,
        GRP_CTL  = 2'd1,
        GRP_STAT = 2'd2,
        GRP_NONE = 2'd3
    } reg_grp_e;

    // Byte count of a length or size code
    function automatic logic [2:0] bytes_of(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/bkpt_regs.sv
`timescale 1ns/1ps
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32,
    parameter int CH_W   = 2,
    parameter int SEL_W  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_we,
    input  logic [SEL_W-1:0]               reg_sel,
    input  logic [ADDR_W-1:0]              reg_wdata,
    input  logic [NUM_CH-1:0]              hit_set,
    output logic [NUM_CH-1:0][ADDR_W-1:0]  ch_addr,
    output bp_ctl_t [NUM_CH-1:0]           ch_ctl,
    output logic [NUM_CH-1:0]              status,
    output logic [ADDR_W-1:0]              reg_rdata
);

    reg_grp_e          grp;
    logic [CH_W-1:0]   idx;
    logic [NUM_CH-1:0] clr;

    assign grp = reg_grp_e'(reg_sel[SEL_W-1 -: 2]);
    assign idx = reg_sel[CH_W-1:0];
    assign clr = (reg_we && grp == GRP_STAT) ? reg_wdata[NUM_CH-1:0] : '0;

    // Per-channel configuration storage
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_addr[g] <= '0;
                ch_ctl[g]  <= '0;
            end else if (reg_we && idx == CH_W'(g)) begin
                if (grp == GRP_ADDR) ch_addr[g] <= reg_wdata;
                if (grp == GRP_CTL)  ch_ctl[g]  <= bp_ctl_t'(reg_wdata[CTL_W-1:0]);
            end
        end

        // R8: a set bit stays set unless a clear targets it
        p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(status[g]) && !$past(clr[g])) |-> status[g]);

        // R8: a match this cycle is visible in status after the edge
        p_status_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            hit_set[g] |=> status[g]);
    end

    // Sticky status: new matches win over a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | hit_set;
    end

    // Readback
    always_comb begin
        reg_rdata = '0;
        unique case (grp)
            GRP_ADDR: begin
                for (int i = 0; i < NUM_CH; i++)
                    if (idx == CH_W'(i)) reg_rdata = ch_addr[i];
            end
            GRP_CTL: begin
                for (int i = 0; i < NUM_CH; i++)
                    if (idx == CH_W'(i)) reg_rdata[CTL_W-1:0] = ch_ctl[i];
            end
            GRP_STAT: reg_rdata[NUM_CH-1:0] = status;
            GRP_NONE: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bkpt_channel.sv
`timescale 1ns/1ps
module bkpt_channel
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  bp_ctl_t           cfg,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_valid,
    input  logic              data_wr,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [1:0]        data_size,
    output logic              hit
);

    localparam int EXT_W = ADDR_W + 1;

    logic [ADDR_W-1:0] mask;
    logic [EXT_W-1:0]  bp_lo, bp_hi, acc_lo, acc_hi;
    logic              exec_hit, kind_ok, data_hit;

    // Breakpoint range, aligned to its own length
    assign mask  = ADDR_W'(bytes_of(cfg.len_code)) - ADDR_W'(1);
    assign bp_lo = {1'b0, cfg_addr & ~mask};
    assign bp_hi = bp_lo + {1'b0, mask};

    // Access range, widened so the last byte cannot wrap
    assign acc_lo = {1'b0, data_addr};
    assign acc_hi = acc_lo + EXT_W'(bytes_of(data_size)) - EXT_W'(1);

    assign exec_hit = cfg.en && (cfg.kind == KIND_EXEC) && fetch_valid
                      && (fetch_addr == cfg_addr);
    assign kind_ok  = (cfg.kind == KIND_RW) || ((cfg.kind == KIND_RD) && !data_wr);
    assign data_hit = cfg.en && data_valid && kind_ok
                      && (acc_lo <= bp_hi) && (bp_lo <= acc_hi);
    assign hit      = exec_hit || data_hit;

    // R3: a read-only channel never reacts to a write
    p_rd_ignores_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.kind == KIND_RD) && data_wr) |-> !hit);

    // R6: disabled or reserved-kind channel is silent
    p_off_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.en || cfg.kind == KIND_OFF) |-> !hit);

    // R5: an execution channel cannot fire without a fetch
    p_exec_needs_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.kind == KIND_EXEC) && !fetch_valid) |-> !hit);

endmodule

// File: rtl/bkpt_trap_out.sv
`timescale 1ns/1ps
module bkpt_trap_out #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit_now,
    output logic [NUM_CH-1:0] hit_vec,
    output logic              trap
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_vec <= '0;
            trap    <= 1'b0;
        end else begin
            hit_vec <= hit_now;
            trap    <= |hit_now;
        end
    end

    // R7: a trap is raised only for a cycle that had a match
    p_trap_from_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(|hit_now));

endmodule

// File: rtl/bkpt_matcher.sv
`timescale 1ns/1ps
module bkpt_matcher
    import bkpt_pkg::*;
#(
    parameter  int NUM_CH = 4,
    parameter  int ADDR_W = 32,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int SEL_W  = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_valid,
    input  logic              data_wr,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [1:0]        data_size,
    output logic              trap,
    output logic [NUM_CH-1:0] hit_vec
);

    logic [NUM_CH-1:0][ADDR_W-1:0] ch_addr;
    bp_ctl_t [NUM_CH-1:0]          ch_ctl;
    logic [NUM_CH-1:0]             status;
    logic [NUM_CH-1:0]             hit_now;

    bkpt_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .CH_W   (CH_W),
        .SEL_W  (SEL_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .hit_set   (hit_now),
        .ch_addr   (ch_addr),
        .ch_ctl    (ch_ctl),
        .status    (status),
        .reg_rdata (reg_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        bkpt_channel #(
            .ADDR_W (ADDR_W)
        ) chan_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_addr    (ch_addr[g]),
            .cfg         (ch_ctl[g]),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .data_valid  (data_valid),
            .data_wr     (data_wr),
            .data_addr   (data_addr),
            .data_size   (data_size),
            .hit         (hit_now[g])
        );

        // R6: a reported hit needs the channel enabled in that cycle
        p_hit_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[g] |-> $past(ch_ctl[g].en));
    end

    bkpt_trap_out #(
        .NUM_CH (NUM_CH)
    ) trap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_now (hit_now),
        .hit_vec (hit_vec),
        .trap    (trap)
    );

    // R7: hits come only from a cycle with some access
    p_hit_needs_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_vec) |-> $past(fetch_valid || data_valid));

    // R8: every reported hit is recorded in status
    p_hit_in_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_vec) |-> ((status & hit_vec) == hit_vec));

endmodule

// File: tb/bkpt_matcher_tb_top.sv
`timescale 1ns/1ps
module bkpt_matcher_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        data_valid = 1'b0;
    logic        data_wr = 1'b0;
    logic [31:0] data_addr = '0;
    logic [1:0]  data_size = '0;
    logic        trap;
    logic [3:0]  hit_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [31:0] m_addr [4];
    logic [4:0]  m_ctl  [4];
    logic [3:0]  m_status;

    always #2.5 clk = ~clk;

    bkpt_matcher dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .data_valid  (data_valid),
        .data_wr     (data_wr),
        .data_addr   (data_addr),
        .data_size   (data_size),
        .trap        (trap),
        .hit_vec     (hit_vec)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic longint nbytes(input int code);
        if (code == 0) return 1;
        if (code == 1) return 2;
        return 4;
    endfunction

    function automatic logic [3:0] model_hits();
        logic [3:0] h = '0;
        for (int c = 0; c < 4; c++) begin
            longint len = nbytes(int'(m_ctl[c][4:3]));
            longint a   = longint'(m_addr[c]);
            longint lo  = a - (a % len);
            longint hi  = lo + len - 1;
            int     k   = int'(m_ctl[c][2:1]);
            if (m_ctl[c][0]) begin
                if (k == 0 && fetch_valid && fetch_addr == m_addr[c]) h[c] = 1'b1;
                if (data_valid && (k == 2 || (k == 1 && !data_wr))) begin
                    longint alo = longint'(data_addr);
                    longint ahi = alo + nbytes(int'(data_size)) - 1;
                    if (alo <= hi && lo <= ahi) h[c] = 1'b1;
                end
            end
        end
        return h;
    endfunction

    function automatic logic [31:0] model_read();
        case (reg_sel[3:2])
            2'd0:    return m_addr[reg_sel[1:0]];
            2'd1:    return {27'd0, m_ctl[reg_sel[1:0]]};
            2'd2:    return {28'd0, m_status};
            default: return 32'd0;
        endcase
    endfunction

    // One clock: model predicts, design is compared after the edge
    task automatic tick();
        logic [3:0] exp = model_hits();
        @(posedge clk);
        if (reg_we) begin
            case (reg_sel[3:2])
                2'd0: m_addr[reg_sel[1:0]] = reg_wdata;
                2'd1: m_ctl[reg_sel[1:0]]  = reg_wdata[4:0];
                2'd2: m_status = m_status & ~reg_wdata[3:0];
                default: ;
            endcase
        end
        m_status = m_status | exp;
        @(negedge clk);
        chk("R7 hit vector vs model", hit_vec, exp);
        chk("R7 trap vs model", trap, exp != 0);
        chk("R9 readback vs model", reg_rdata, model_read());
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] sel, input logic [31:0] exp, input string tag);
        reg_sel = sel;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic acc(input bit fv, input logic [31:0] fa, input bit dv, input bit dw,
                       input logic [31:0] da, input logic [1:0] ds,
                       input logic [3:0] exp, input string tag);
        fetch_valid = fv; fetch_addr = fa;
        data_valid = dv; data_wr = dw; data_addr = da; data_size = ds;
        tick();
        chk(tag, hit_vec, exp);
        fetch_valid = 1'b0; data_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin m_addr[c] = '0; m_ctl[c] = '0; end
        m_status = '0;
        repeat (3) @(negedge clk);
        chk("R1 trap in reset", trap, 0);
        chk("R1 hit_vec in reset", hit_vec, 0);
        rst_n = 1'b1;
        rd(4'd8, 0, "R1 status after reset");
        rd(4'd4, 0, "R1 control after reset");
        rd(4'd0, 0, "R1 address after reset");

        // ch0 exec @1000; ch1 read-only 4B @2002; ch2 read/write 2B @2001; ch3 rw disabled
        wr(4'd0, 32'h1000); wr(4'd4, 32'h01);
        wr(4'd1, 32'h2002); wr(4'd5, 32'h13);
        wr(4'd2, 32'h2001); wr(4'd6, 32'h0D);
        wr(4'd3, 32'h3000); wr(4'd7, 32'h04);
        rd(4'd5, 32'h13, "R9 control readback");
        rd(4'd1, 32'h2002, "R9 address readback");
        rd(4'd12, 0, "R9 reserved group reads zero");

        acc(1, 32'h1000, 0, 0, 0, 0, 4'b0001, "R2 exact fetch match");
        acc(1, 32'h1001, 0, 0, 0, 0, 4'b0000, "R2 fetch one past");
        acc(0, 0, 1, 0, 32'h1000, 0, 4'b0000, "R5 exec channel ignores data");
        acc(1, 32'h2002, 0, 0, 0, 0, 4'b0000, "R5 data channels ignore fetch");
        acc(0, 0, 1, 0, 32'h2003, 0, 4'b0010, "R5 last byte of 4-byte range");
        acc(0, 0, 1, 0, 32'h2004, 0, 4'b0000, "R5 byte after range");
        acc(0, 0, 1, 1, 32'h2000, 0, 4'b0100, "R3 read-only ignores write");
        acc(0, 0, 1, 0, 32'h2000, 0, 4'b0110, "R4 read hits both data kinds");
        acc(0, 0, 1, 0, 32'h1FFE, 2, 4'b0110, "R5 straddling access overlaps");
        acc(0, 0, 1, 0, 32'h1FFC, 2, 4'b0000, "R5 adjacent access no overlap");
        acc(0, 0, 1, 1, 32'h3000, 0, 4'b0000, "R6 disabled channel silent");
        acc(1, 32'h1000, 1, 0, 32'h1FFF, 2, 4'b0111, "R7 parallel three-channel hit");
        chk("R7 trap with several hits", trap, 1);
        tick();
        chk("R7 trap is single pulse", trap, 0);

        rd(4'd8, 32'h7, "R8 sticky status");
        wr(4'd8, 32'h2);
        rd(4'd8, 32'h5, "R8 write-one clears bit");
        reg_we = 1'b1; reg_sel = 4'd8; reg_wdata = 32'h1;
        fetch_valid = 1'b1; fetch_addr = 32'h1000;
        tick();
        reg_we = 1'b0; fetch_valid = 1'b0;
        rd(4'd8, 32'h5, "R8 match wins over clear");

        wr(4'd7, 32'h07);
        acc(0, 0, 1, 1, 32'h3000, 0, 4'b0000, "R6 reserved kind silent");
        rd(4'd8, 32'h5, "R6 status untouched");
        wr(4'd7, 32'h05);
        acc(0, 0, 1, 1, 32'h3000, 0, 4'b1000, "R4 write hit");
        wr(4'd8, 32'hF);
        rd(4'd8, 32'h0, "R8 full clear");

        // Random phase against the model
        for (int n = 0; n < 3000; n++) begin
            if (($urandom % 8) == 0) begin
                logic [3:0] s = 4'($urandom % 10);
                reg_we = 1'b1; reg_sel = s;
                reg_wdata = (s[3:2] == 2'd0) ? 32'h1000 + ($urandom % 16) : $urandom;
            end else begin
                reg_we = 1'b0; reg_sel = 4'($urandom % 10);
            end
            fetch_valid = 1'($urandom); fetch_addr = 32'h1000 + ($urandom % 16);
            data_valid = 1'($urandom); data_wr = 1'($urandom);
            data_addr = 32'h0FFC + ($urandom % 24); data_size = 2'($urandom);
            tick();
        end
        reg_we = 1'b0; fetch_valid = 1'b0; data_valid = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule